// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block watches the slots of a memory request tracker and raises an alarm when a request has waited too long for its response. The tracker owns two groups of slots, one for read-class requests and one for write-class requests. For every slot it presents a valid bit, the line address and the cycle stamp taken when the request was issued. The watchdog keeps a free-running 32-bit cycle counter and publishes it, so that the tracker stamps its requests in the same time base.

The check is periodic rather than continuous. An insertion reported by the tracker arms the watchdog, which then examines every slot of both groups exactly one age limit later. After each examination it re-arms for another interval only while requests are still pending, and otherwise it goes idle until the next insertion. While the drain input is high the watchdog never arms. The first overdue entry it finds is latched on sticky outputs together with its address and age. A registered count of outstanding entries is also reported.

Top module: `age_watchdog`

## Requirements
- R1: While reset is held, deadlock, deadlock_addr, deadlock_age, outstanding and now_cycle are all zero.
- R2: now_cycle advances by exactly one on every clock edge out of reset, wrapping modulo 2^32.
- R3: A req_insert sampled while the watchdog is idle and drain_req is low schedules one examination at the edge where now_cycle equals the value it had at the insertion edge plus age_limit. No overdue entry is reported before that edge.
- R4: While drain_req is high, req_insert does not arm the watchdog, and an examination does not re-arm it.
- R5: An entry is overdue when (now_cycle − issue) modulo 2^32 is greater than or equal to age_limit. Equality counts as overdue, and issue stamps that lie before a wrap of the counter give the correct age.
- R6: Every examination covers both the read and the write slots. When several entries are overdue, the one reported is chosen by priority: read slots from index 0 upward first, then write slots from index 0 upward.
- R7: After an examination the watchdog re-arms for another age_limit interval when any slot is valid or req_insert is high in that cycle, and drain_req is low. Otherwise it goes idle.
- R8: Once deadlock is set it stays set, and deadlock_addr and deadlock_age keep the values of the first reported entry, until reset.
- R9: outstanding equals the number of valid read slots plus valid write slots as sampled at the previous clock edge.
- R10: Without an insertion the watchdog never examines slots, so an overdue entry present while it is idle is not reported.

Top module port list, in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| age_limit | input | 32 | Age limit in cycles, greater than zero |
| req_insert | input | 1 | One-cycle pulse when the tracker accepts a new request |
| drain_req | input | 1 | High while the system drains; blocks arming |
| rd_valid | input | NRD | Valid bit per read slot |
| rd_addr | input | NRD*AW | Line address per read slot, slot i at bits i*AW upward |
| rd_issue | input | NRD*32 | Issue stamp per read slot, slot i at bits i*32 upward |
| wr_valid | input | NWR | Valid bit per write slot |
| wr_addr | input | NWR*AW | Line address per write slot |
| wr_issue | input | NWR*32 | Issue stamp per write slot |
| now_cycle | output | 32 | Current cycle stamp |
| outstanding | output | $clog2(NRD+NWR+1) | Registered count of valid slots |
| deadlock | output | 1 | Sticky flag for an overdue request |
| deadlock_addr | output | AW | Line address of the reported entry |
| deadlock_age | output | 32 | Age of the reported entry at the examination edge |

## Verification
On every cycle the assertions check the counter step, the sticky hold of the alarm and its captured fields, the outstanding count against the valid bits of the previous cycle, that the watchdog arms only after a non-draining insertion, and that a freshly reported age is not below the limit. The examination timing, the exact age value, the read-before-write and index priority, the equality boundary, wrap-around of issue stamps, and the idle, no-insert and drain-suppressed re-arm cases depend on sequences of events. Only the bench scenarios can show those, by comparing the alarm outputs against ages the bench computes itself.

// File: rtl/age_wd_pkg.sv
package age_wd_pkg;

    localparam int STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic {
        SCHED_IDLE  = 1'b0,
        SCHED_ARMED = 1'b1
    } sched_e;

    typedef struct packed {
        logic   found;
        stamp_t age;
    } scan_hit_t;

    // modular distance between two stamps
    function automatic stamp_t elapsed(stamp_t now, stamp_t then);
        return now - then;
    endfunction

endpackage

// File: rtl/age_wd_sched.sv
module age_wd_sched
    import age_wd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stamp_t limit,
    input  logic   insert,
    input  logic   drain,
    input  logic   any_pending,
    output stamp_t now,
    output logic   check_now,
    output logic   armed
);

    sched_e state;
    stamp_t due;

    assign armed     = (state == SCHED_ARMED);
    assign check_now = armed && (now == due);

    always_ff @(posedge clk) begin
        if (rst) begin
            now   <= '0;
            due   <= '0;
            state <= SCHED_IDLE;
        end else begin
            now <= now + 1'b1;
            case (state)
                SCHED_IDLE: begin
                    if (insert && !drain) begin
                        due   <= now + limit;
                        state <= SCHED_ARMED;
                    end
                end
                SCHED_ARMED: begin
                    if (now == due) begin
                        if ((any_pending || insert) && !drain) begin
                            due <= now + limit;
                        end else begin
                            state <= SCHED_IDLE;
                        end
                    end
                end
                default: state <= SCHED_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/age_wd_scan.sv
module age_wd_scan
    import age_wd_pkg::*;
#(
    parameter int NS = 8,
    parameter int AW = 32
) (
    input  stamp_t              now,
    input  stamp_t              limit,
    input  logic [NS-1:0]       valid,
    input  logic [NS*AW-1:0]    addr,
    input  logic [NS*STAMP_W-1:0] issue,
    output scan_hit_t           hit,
    output logic [AW-1:0]       hit_addr
);

    logic [NS-1:0] late;
    stamp_t        age [NS];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        assign age[g]  = elapsed(now, issue[g*STAMP_W +: STAMP_W]);
        assign late[g] = valid[g] && (age[g] >= limit);
    end

    // lowest index wins: walk downward so the last write is the lowest
    always_comb begin
        hit      = '0;
        hit_addr = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (late[i]) begin
                hit.found = 1'b1;
                hit.age   = age[i];
                hit_addr  = addr[i*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/age_wd_count.sv
module age_wd_count #(
    parameter int NS = 8,
    parameter int CW = $clog2(NS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] valid,
    output logic [CW-1:0] count
);

    logic [CW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < NS; i++) begin
            sum = sum + CW'(valid[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= sum;
    end

endmodule

// File: rtl/age_watchdog.sv
module age_watchdog
    import age_wd_pkg::*;
#(
    parameter int NRD = 4,
    parameter int NWR = 4,
    parameter int AW  = 32,
    localparam int NS = NRD + NWR,
    localparam int CW = $clog2(NS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [STAMP_W-1:0]     age_limit,
    input  logic                   req_insert,
    input  logic                   drain_req,
    input  logic [NRD-1:0]         rd_valid,
    input  logic [NRD*AW-1:0]      rd_addr,
    input  logic [NRD*STAMP_W-1:0] rd_issue,
    input  logic [NWR-1:0]         wr_valid,
    input  logic [NWR*AW-1:0]      wr_addr,
    input  logic [NWR*STAMP_W-1:0] wr_issue,
    output logic [STAMP_W-1:0]     now_cycle,
    output logic [CW-1:0]          outstanding,
    output logic                   deadlock,
    output logic [AW-1:0]          deadlock_addr,
    output logic [STAMP_W-1:0]     deadlock_age
);

    // read slots occupy the low indices so they win the priority scan
    logic [NS-1:0]         all_valid;
    logic [NS*AW-1:0]      all_addr;
    logic [NS*STAMP_W-1:0] all_issue;

    assign all_valid = {wr_valid, rd_valid};
    assign all_addr  = {wr_addr, rd_addr};
    assign all_issue = {wr_issue, rd_issue};

    logic      check_now;
    logic      armed;
    scan_hit_t hit;
    logic [AW-1:0] hit_addr;

    age_wd_sched u_sched (
        .clk         (clk),
        .rst         (rst),
        .limit       (age_limit),
        .insert      (req_insert),
        .drain       (drain_req),
        .any_pending (|all_valid),
        .now         (now_cycle),
        .check_now   (check_now),
        .armed       (armed)
    );

    age_wd_scan #(.NS(NS), .AW(AW)) u_scan (
        .now      (now_cycle),
        .limit    (age_limit),
        .valid    (all_valid),
        .addr     (all_addr),
        .issue    (all_issue),
        .hit      (hit),
        .hit_addr (hit_addr)
    );

    age_wd_count #(.NS(NS), .CW(CW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .valid (all_valid),
        .count (outstanding)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            deadlock      <= 1'b0;
            deadlock_addr <= '0;
            deadlock_age  <= '0;
        end else if (check_now && hit.found && !deadlock) begin
            deadlock      <= 1'b1;
            deadlock_addr <= hit_addr;
            deadlock_age  <= hit.age;
        end
    end

endmodule

// File: rtl/age_watchdog_chk.sv
module age_watchdog_chk
    import age_wd_pkg::*;
#(
    parameter int NRD = 4,
    parameter int NWR = 4,
    parameter int AW  = 32,
    parameter int CW  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [STAMP_W-1:0] age_limit,
    input logic               req_insert,
    input logic               drain_req,
    input logic [NRD-1:0]     rd_valid,
    input logic [NWR-1:0]     wr_valid,
    input logic [STAMP_W-1:0] now_cycle,
    input logic [CW-1:0]      outstanding,
    input logic               deadlock,
    input logic [AW-1:0]      deadlock_addr,
    input logic [STAMP_W-1:0] deadlock_age,
    input logic               armed
);

    a_r2_counter_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> now_cycle == STAMP_W'($past(now_cycle) + 1'b1));

    a_r8_sticky_alarm: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock && $stable(deadlock_addr) && $stable(deadlock_age));

    a_r9_count_match: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> outstanding == CW'($countones($past({wr_valid, rd_valid}))));

    a_r4_drain_no_arm: assert property (@(posedge clk) disable iff (rst)
        (!armed && drain_req) |=> !armed);

    a_r3_arm_on_insert: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(req_insert && !drain_req));

    a_r5_age_over_limit: assert property (@(posedge clk) disable iff (rst)
        $rose(deadlock) |-> deadlock_age >= $past(age_limit));

endmodule

bind age_watchdog age_watchdog_chk #(
    .NRD(NRD), .NWR(NWR), .AW(AW), .CW(CW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .age_limit     (age_limit),
    .req_insert    (req_insert),
    .drain_req     (drain_req),
    .rd_valid      (rd_valid),
    .wr_valid      (wr_valid),
    .now_cycle     (now_cycle),
    .outstanding   (outstanding),
    .deadlock      (deadlock),
    .deadlock_addr (deadlock_addr),
    .deadlock_age  (deadlock_age),
    .armed         (armed)
);

// File: tb/sim_age_watchdog.sv
`timescale 1ns/1ps
module sim_age_watchdog;

    localparam int NRD = 4;
    localparam int NWR = 4;
    localparam int AW  = 32;
    localparam int CW  = $clog2(NRD + NWR + 1);

    typedef struct packed {
        int lim;
        int sa;
        int oa;
        int sb;
        int ob;
    } vec_t;

    // slot indices: 0..3 read slots, 4..7 write slots; offsets relative to insert stamp
    localparam vec_t VECS [6] = '{
        '{10, 2,  -3, 6,  1},
        '{ 7, 5,   0, 1,  1},
        '{ 5, 3,  -4, 0, -2},
        '{ 6, 1,   1, 7,  2},
        '{ 4, 4, -20, 6, -1},
        '{ 3, 0,   1, 3,  0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       age_limit = 32'd4;
    logic              req_insert = 1'b0;
    logic              drain_req = 1'b0;
    logic [NRD-1:0]    rd_valid = '0;
    logic [NRD*AW-1:0] rd_addr = '0;
    logic [NRD*32-1:0] rd_issue = '0;
    logic [NWR-1:0]    wr_valid = '0;
    logic [NWR*AW-1:0] wr_addr = '0;
    logic [NWR*32-1:0] wr_issue = '0;
    logic [31:0]       now_cycle;
    logic [CW-1:0]     outstanding;
    logic              deadlock;
    logic [AW-1:0]     deadlock_addr;
    logic [31:0]       deadlock_age;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    age_watchdog #(.NRD(NRD), .NWR(NWR), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .age_limit(age_limit), .req_insert(req_insert),
        .drain_req(drain_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_issue(rd_issue), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_issue(wr_issue), .now_cycle(now_cycle), .outstanding(outstanding),
        .deadlock(deadlock), .deadlock_addr(deadlock_addr),
        .deadlock_age(deadlock_age)
    );

    function automatic logic [31:0] addr_of(int g);
        return 32'hA000_0000 + 32'(g * 64);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_slot(input int g, input logic v, input logic [31:0] iss);
        if (g < NRD) begin
            rd_valid[g]            = v;
            rd_addr[g*AW +: AW]    = addr_of(g);
            rd_issue[g*32 +: 32]   = iss;
        end else begin
            wr_valid[g-NRD]          = v;
            wr_addr[(g-NRD)*AW +: AW]  = addr_of(g);
            wr_issue[(g-NRD)*32 +: 32] = iss;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; req_insert = 1'b0; drain_req = 1'b0;
        rd_valid = '0; wr_valid = '0; rd_issue = '0; wr_issue = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // pulse req_insert over one edge; returns the stamp seen at that edge
    task automatic pulse_insert(output logic [31:0] t0);
        t0 = now_cycle;
        req_insert = 1'b1;
        @(negedge clk);
        req_insert = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] t0;
        logic [31:0] t1;

        // R1: reset values
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(deadlock == 1'b0, "R1 deadlock", 32'(deadlock), 0);
        check(deadlock_addr == '0 && deadlock_age == '0, "R1 fields", deadlock_age, 0);
        check(outstanding == '0, "R1 outstanding", 32'(outstanding), 0);
        check(now_cycle == '0, "R1 now_cycle", now_cycle, 0);

        // vector table: R3 R5 R6 R9
        for (int v = 0; v < 6; v++) begin
            vec_t   vc;
            bit     fa, fb, found;
            int     win;
            logic [31:0] eage;
            vc = VECS[v];
            do_reset();
            age_limit = 32'(vc.lim);
            @(negedge clk);
            t0 = now_cycle;
            set_slot(vc.sa, 1'b1, t0 + 32'(vc.oa));
            set_slot(vc.sb, 1'b1, t0 + 32'(vc.ob));
            pulse_insert(t0);
            repeat (vc.lim - 1) @(negedge clk);
            check(deadlock == 1'b0, "R3 no alarm before examination", 32'(deadlock), 0);
            @(negedge clk);
            fa = (vc.oa <= 0);
            fb = (vc.ob <= 0);
            found = fa || fb;
            win = -1;
            if (fa) win = vc.sa;
            if (fb && (win < 0 || vc.sb < win)) win = vc.sb;
            eage = (win == vc.sa) ? 32'(vc.lim - vc.oa) : 32'(vc.lim - vc.ob);
            check(deadlock == found, "R5 overdue decision", 32'(deadlock), 32'(found));
            if (found) begin
                check(deadlock_addr == addr_of(win), "R6 priority address",
                      deadlock_addr, addr_of(win));
                check(deadlock_age == eage, "R5 reported age", deadlock_age, eage);
            end
            check(outstanding == CW'(2), "R9 outstanding", 32'(outstanding), 2);
        end

        // R2: counter step
        @(negedge clk);
        t1 = now_cycle;
        repeat (5) @(negedge clk);
        check(now_cycle == t1 + 32'd5, "R2 counter step", now_cycle, t1 + 32'd5);

        // R4: drain blocks arming
        do_reset();
        age_limit = 32'd4;
        drain_req = 1'b1;
        @(negedge clk);
        set_slot(0, 1'b1, now_cycle - 32'd5);
        pulse_insert(t0);
        repeat (12) @(negedge clk);
        check(deadlock == 1'b0, "R4 insert ignored while draining", 32'(deadlock), 0);
        check(outstanding == CW'(1), "R9 outstanding single", 32'(outstanding), 1);

        // R10: no insertion, no examination
        do_reset();
        age_limit = 32'd3;
        @(negedge clk);
        set_slot(5, 1'b1, now_cycle - 32'd9);
        repeat (20) @(negedge clk);
        check(deadlock == 1'b0, "R10 idle without insert", 32'(deadlock), 0);

        // R7: re-arm while pending, then R8 sticky
        do_reset();
        age_limit = 32'd5;
        @(negedge clk);
        t0 = now_cycle;
        set_slot(1, 1'b1, t0 + 32'd2);
        pulse_insert(t0);
        repeat (5) @(negedge clk);
        check(deadlock == 1'b0, "R7 first examination clean", 32'(deadlock), 0);
        repeat (5) @(negedge clk);
        check(deadlock == 1'b1, "R7 re-armed examination", 32'(deadlock), 1);
        check(deadlock_age == 32'd8, "R7 age at second examination", deadlock_age, 8);
        set_slot(1, 1'b0, '0);
        set_slot(0, 1'b1, now_cycle - 32'd50);
        repeat (12) @(negedge clk);
        check(deadlock == 1'b1, "R8 alarm held", 32'(deadlock), 1);
        check(deadlock_addr == addr_of(1), "R8 address held", deadlock_addr, addr_of(1));
        check(deadlock_age == 32'd8, "R8 age held", deadlock_age, 8);

        // R7: idle after examination with nothing pending
        do_reset();
        age_limit = 32'd4;
        @(negedge clk);
        pulse_insert(t0);
        repeat (4) @(negedge clk);
        set_slot(2, 1'b1, now_cycle - 32'd10);
        repeat (12) @(negedge clk);
        check(deadlock == 1'b0, "R7 idle when empty", 32'(deadlock), 0);

        // R4: drain suppresses re-arm
        do_reset();
        age_limit = 32'd4;
        @(negedge clk);
        t0 = now_cycle;
        set_slot(0, 1'b1, t0 + 32'd1);
        pulse_insert(t0);
        drain_req = 1'b1;
        repeat (12) @(negedge clk);
        check(deadlock == 1'b0, "R4 no re-arm while draining", 32'(deadlock), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule